// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block runs the modem-line handshake of one serial channel without software help. On the receive side it watches the fill level of the receive queue. It drives the active-low request-to-send line high, which stops the far end, as soon as the level reaches a programmed threshold. It drives the line low again only after the level has fallen a fixed hysteresis step below that threshold. When automatic receive flow control is off, the line follows a software-written modem-control bit.

On the transmit side the block synchronizes the active-low clear-to-send input and produces a transmit-permit signal for the serializer. Permission is withdrawn only at a character boundary, so a character already on the wire always completes. A change on the synchronized clear-to-send line can raise an interrupt request. That request is gated by both an interrupt-enable bit and an enhanced-feature enable.

Top module: `uart_flowctl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1, `tx_permit` is 0 and `cts_irq` is 0.
- R2: With `auto_rts_en`=1, if `rx_level >= rts_trig` in a cycle, `rts_n` is 1 after the next clock edge. With `rts_trig`=0 the line therefore stays high.
- R3: With `auto_rts_en`=1, if `rx_level + HYST < rts_trig`, `rts_n` is 0 after the next edge. Levels in between leave `rts_n` unchanged.
- R4: With `auto_rts_en`=0, `rts_n` equals the inverse of `sw_rts` one cycle later.
- R5: With `auto_cts_en`=0, `tx_permit` is 1 one cycle later, whatever the state of `cts_n`.
- R6: `cts_n` passes through SYNC_STAGES flip-flops before use, so a change reaches `tx_permit` SYNC_STAGES+1 edges after it is applied.
- R7: With `auto_cts_en`=1 and `tx_permit`=1, `tx_permit` falls only after an edge at which `char_bound`=1 and synchronized CTS is high (deasserted). Without `char_bound` it stays 1.
- R8: With `auto_cts_en`=1 and `tx_permit`=0, `tx_permit` rises one edge after synchronized CTS is low, without needing `char_bound`.
- R9: Each change of synchronized CTS while `enh_en`=1 and `cts_ie`=1 sets `cts_irq` one edge later, SYNC_STAGES+1 edges after the pin change.
- R10: With `enh_en`=0, a CTS change does not set `cts_irq`, even when `cts_ie`=1.
- R11: `irq_ack`=1 clears `cts_irq` after the next edge. If a new enabled CTS change occurs in the same cycle, the set wins and `cts_irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | Automatic receive-side flow control enable |
| auto_cts_en | input | 1 | Automatic transmit gating enable |
| enh_en | input | 1 | Enhanced-feature enable that qualifies the CTS interrupt |
| cts_ie | input | 1 | CTS change interrupt enable |
| sw_rts | input | 1 | Software RTS request, 1 = assert (drive line low) |
| rx_level | input | LVL_W | Current receive queue fill level |
| rts_trig | input | LVL_W | Fill level at which RTS is deasserted |
| char_bound | input | 1 | High in cycles where the transmitter sits between characters |
| irq_ack | input | 1 | Clears the pending CTS interrupt |
| cts_n | input | 1 | Asynchronous active-low clear-to-send pin |
| rts_n | output | 1 | Active-low request-to-send pin |
| tx_permit | output | 1 | Transmitter may start a character |
| cts_irq | output | 1 | Pending CTS change interrupt |

## Verification
The bench builds the block with LVL_W=7, HYST=3 and SYNC_STAGES=2. Because the hysteresis step is small, the band between the clear and trip points has only a few levels, and a short ramp of fill levels can reach both edges of it. With a 7-bit level, a threshold of 0 and full-scale levels can be driven directly. With two synchronizer stages, the three-edge latency on CTS is short enough that an acknowledge can be made to coincide with a fresh CTS change.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef struct packed {
        logic permit;
        logic prev;
        logic irq;
    } cts_st_t;

    typedef struct packed {
        logic rts_n;
    } rts_st_t;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
    import fc_pkg::*;
#(
    parameter int LVL_W = 7,
    parameter int HYST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    output logic             rts_n
);
    localparam int EXT_W = LVL_W + 1;
    localparam logic [EXT_W-1:0] HYST_X = EXT_W'(HYST);

    rts_st_t st_d, st_q;
    logic    trip, clear_ok;

    always_comb begin
        trip     = (level >= trig);
        clear_ok = ({1'b0, level} + HYST_X) < {1'b0, trig};
        st_d     = st_q;
        if (!auto_en)      st_d.rts_n = ~sw_rts;
        else if (trip)     st_d.rts_n = 1'b1;
        else if (clear_ok) st_d.rts_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rts_n: 1'b1};
        else        st_q <= st_d;
    end

    assign rts_n = st_q.rts_n;

    p_rts_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level >= trig) |=> rts_n);
    p_rts_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && level < trig && ({1'b0, level} + HYST_X) >= {1'b0, trig})
        |=> $stable(rts_n));
    p_rts_manual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && sw_rts) |=> !rts_n);
endmodule

// File: rtl/fc_cts_ctrl.sv
module fc_cts_ctrl
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cts_s,
    input  logic auto_en,
    input  logic char_bound,
    input  logic enh_en,
    input  logic cts_ie,
    input  logic irq_ack,
    output logic tx_permit,
    output logic cts_irq
);
    cts_st_t st_d, st_q;
    logic    chg, irq_gate;

    always_comb begin
        chg      = (cts_s != st_q.prev);
        irq_gate = enh_en & cts_ie;
        st_d      = st_q;
        st_d.prev = cts_s;
        if (!auto_en)
            st_d.permit = 1'b1;
        else if (!st_q.permit)
            st_d.permit = ~cts_s;
        else if (char_bound)
            st_d.permit = ~cts_s;
        if (chg && irq_gate) st_d.irq = 1'b1;
        else if (irq_ack)    st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{permit: 1'b0, prev: 1'b1, irq: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_permit = st_q.permit;
    assign cts_irq   = st_q.irq;

    p_permit_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> tx_permit);
    p_mid_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && tx_permit && !char_bound) |=> tx_permit);
    p_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !tx_permit && !cts_s) |=> tx_permit);
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && enh_en && cts_ie) |=> cts_irq);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_irq && !enh_en) |=> !cts_irq);
    p_irq_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(chg && irq_gate)) |=> !cts_irq);
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
    parameter int LVL_W       = 7,
    parameter int HYST        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             enh_en,
    input  logic             cts_ie,
    input  logic             sw_rts,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rts_trig,
    input  logic             char_bound,
    input  logic             irq_ack,
    input  logic             cts_n,
    output logic             rts_n,
    output logic             tx_permit,
    output logic             cts_irq
);
    logic cts_sync;

    fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cts_n),
        .dout (cts_sync)
    );

    fc_rts_ctrl #(.LVL_W(LVL_W), .HYST(HYST)) u_rts (
        .clk    (clk),
        .rst_n  (rst_n),
        .auto_en(auto_rts_en),
        .sw_rts (sw_rts),
        .level  (rx_level),
        .trig   (rts_trig),
        .rts_n  (rts_n)
    );

    fc_cts_ctrl u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_s     (cts_sync),
        .auto_en   (auto_cts_en),
        .char_bound(char_bound),
        .enh_en    (enh_en),
        .cts_ie    (cts_ie),
        .irq_ack   (irq_ack),
        .tx_permit (tx_permit),
        .cts_irq   (cts_irq)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (rts_n && !tx_permit && !cts_irq)));
endmodule

// File: tb/uart_flowctl_test.sv
module uart_flowctl_test;
    localparam int LW = 7;
    localparam int HY = 3;
    localparam int SY = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_rts_en = 0, auto_cts_en = 0, enh_en = 0, cts_ie = 0, sw_rts = 0;
    logic [LW-1:0] rx_level = '0, rts_trig = '0;
    logic char_bound = 0, irq_ack = 0, cts_n = 1;
    logic rts_n, tx_permit, cts_irq;

    int n_chk = 0, n_fail = 0;

    // reference model state
    int  m_rts = 1, m_perm = 0, m_irq = 0, m_prev = 1;
    int  m_sh[SY];
    string t_rts = "R1", t_perm = "R1", t_irq = "R1";

    always #4 clk = ~clk;

    uart_flowctl #(.LVL_W(LW), .HYST(HY), .SYNC_STAGES(SY)) uut (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .enh_en(enh_en), .cts_ie(cts_ie), .sw_rts(sw_rts), .rx_level(rx_level),
        .rts_trig(rts_trig), .char_bound(char_bound), .irq_ack(irq_ack), .cts_n(cts_n),
        .rts_n(rts_n), .tx_permit(tx_permit), .cts_irq(cts_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rts = 1; m_perm = 0; m_irq = 0; m_prev = 1;
            foreach (m_sh[i]) m_sh[i] = 1;
            t_rts = "R1"; t_perm = "R1"; t_irq = "R1";
        end else begin
            int cs;
            bit edge_seen;
            cs = m_sh[SY-1];
            edge_seen = (cs != m_prev);
            if (!auto_rts_en) begin m_rts = !sw_rts; t_rts = "R4"; end
            else if (int'(rx_level) >= int'(rts_trig)) begin m_rts = 1; t_rts = "R2"; end
            else if (int'(rx_level) + HY < int'(rts_trig)) begin m_rts = 0; t_rts = "R3"; end
            else t_rts = "R3";
            if (!auto_cts_en) begin m_perm = 1; t_perm = "R5"; end
            else if (m_perm == 0) begin m_perm = !cs; t_perm = "R8"; end
            else if (char_bound) begin m_perm = !cs; t_perm = "R7"; end
            else t_perm = "R7";
            if (edge_seen && enh_en && cts_ie) begin m_irq = 1; t_irq = "R9"; end
            else if (irq_ack) begin m_irq = 0; t_irq = "R11"; end
            else t_irq = enh_en ? "R9" : "R10";
            m_prev = cs;
            for (int i = SY - 1; i > 0; i--) m_sh[i] = m_sh[i-1];
            m_sh[0] = cts_n;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        chk({t_rts, " rts_n"}, rts_n, m_rts);
        chk({t_perm, " tx_permit"}, tx_permit, m_perm);
        chk({t_irq, " cts_irq"}, cts_irq, m_irq);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        step(150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 rts_n reset", rts_n, 1);
        chk("R1 tx_permit reset", tx_permit, 0);
        chk("R1 cts_irq reset", cts_irq, 0);
        rst_n = 1;
        // manual RTS
        sw_rts = 1; step(1);
        chk("R4 manual assert", rts_n, 0);
        sw_rts = 0; step(1);
        chk("R4 manual release", rts_n, 1);
        sw_rts = 1; step(1);
        // auto RTS with hysteresis, threshold 16
        auto_rts_en = 1; rts_trig = 16;
        for (int l = 0; l <= 20; l++) begin rx_level = LW'(l); step(1); end
        chk("R2 tripped at high level", rts_n, 1);
        rx_level = 13; step(1);
        chk("R3 band holds", rts_n, 1);
        rx_level = 12; step(1);
        chk("R3 cleared below band", rts_n, 0);
        rx_level = 14; step(1);
        chk("R3 band holds low", rts_n, 0);
        rx_level = 16; step(1);
        chk("R2 trip at equal", rts_n, 1);
        rts_trig = 0; rx_level = 0; step(2);
        chk("R2 zero threshold", rts_n, 1);
        rts_trig = 127; rx_level = 127; step(1);
        chk("R2 full scale", rts_n, 1);
        rx_level = 123; step(1);
        chk("R3 full scale clear", rts_n, 0);
        // auto CTS off
        cts_n = 1; step(1);
        chk("R5 permit without gating", tx_permit, 1);
        // auto CTS on, CTS deasserted
        auto_cts_en = 1; char_bound = 1; step(4);
        chk("R7 drop at boundary", tx_permit, 0);
        cts_n = 0; char_bound = 0; step(2);
        chk("R6 still synchronizing", tx_permit, 0);
        step(1);
        chk("R8 resume without boundary", tx_permit, 1);
        cts_n = 1; step(10);
        chk("R7 character finishes", tx_permit, 1);
        char_bound = 1; step(1);
        chk("R7 halt at boundary", tx_permit, 0);
        char_bound = 0; cts_n = 0; step(3);
        // interrupt gating
        cts_ie = 1; enh_en = 0; cts_n = 1; step(4);
        chk("R10 no irq without enh", cts_irq, 0);
        enh_en = 1; cts_n = 0; step(2);
        chk("R9 not yet", cts_irq, 0);
        step(1);
        chk("R9 irq after change", cts_irq, 1);
        irq_ack = 1; step(1);
        chk("R11 ack clears", cts_irq, 0);
        irq_ack = 0; cts_n = 1; step(2);
        irq_ack = 1; step(1);
        chk("R11 set wins over ack", cts_irq, 1);
        irq_ack = 0; step(1);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            auto_rts_en = ($urandom % 8) != 0;
            auto_cts_en = ($urandom % 6) != 0;
            enh_en = $urandom % 2; cts_ie = $urandom % 2;
            sw_rts = $urandom % 2; irq_ack = ($urandom % 5) == 0;
            char_bound = ($urandom % 4) == 0;
            if (($urandom % 5) == 0) cts_n = ~cts_n;
            rx_level = LW'($urandom % 40); rts_trig = LW'(10 + $urandom % 12);
            if (k == 1500) rts_trig = 2;
            step(1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule